// File: doc/BRIEF.md
# Three-Stage Pipeline Bypass and Hazard Controller

This block steers operands for a three-stage scalar integer pipeline. Stage 1 fetches, decodes, reads registers, resolves branches and computes memory addresses. Stage 2 executes and accesses the data cache. Stage 3 writes the register file. The controller receives the stage-1 instruction's register indices, write enable and class code. It tracks stage 2 and stage 3 internally. It also takes the stage-2 ALU output and load data.

For stage 2, the controller works out in stage 1 whether each operand needs a bypass. It registers that choice as a two-bit mux select, so stage 2 only has to switch a mux. For stage 1, it feeds the branch comparator and the address adder. These can take a value from the register file, from the live stage-2 ALU output, or from the stage-3 result. When a dependency cannot be bypassed, the controller holds stage 1 for one cycle and sends a bubble into stage 2.

A small behavioural register file and the operand muxes are included, so operand values can be seen at the ports. Branches have no delay slot: a compare followed directly by a branch on its result resolves without a stall.

Top module: `bypass_hazard_ctrl`

## Requirements
- R1: While reset is held and after its release with no valid instruction, the stall and stage-2 valid outputs are low, every select output is 0, and both stage-2 operands are zero.
- R2: The stage-2 select codes are registered when an instruction moves from stage 1 to stage 2. The codes are: 0 for the register-file value read in stage 1; 1 for the result of the instruction one ahead when that is a non-load writer; 2 for the load data of the instruction one ahead; 3 for the value written back by the instruction two ahead.
- R3: Each stage-2 operand equals the value of the most recent older instruction that wrote that register, or the reset value zero if there is none.
- R4: When a source matches the destinations of both the instruction one ahead and the instruction two ahead, the one-ahead (younger) value is chosen.
- R5: Register index 0 is never bypassed. It always reads as zero, and a source of 0 always gets select code 0.
- R6: A load followed directly by an instruction of class ALU, immediate-ALU, compare or store-data use never stalls. The loaded value reaches the next instruction's stage-2 operand.
- R7: A compare (class 2) in stage 2 followed directly by a branch that reads its destination gives comparator select 1, carries the live ALU output to the comparator, and does not stall.
- R8: An immediate-ALU instruction (class 1) in stage 2 followed directly by a load or store whose base register is its destination gives address select 1, carries the live ALU output to the address adder, and does not stall.
- R9: A stage-1 branch or address source written by the instruction in stage 3 (and not by stage 2) gets early select 3 and the stage-3 result.
- R10: Class codes are 0 ALU, 1 immediate-ALU, 2 compare, 3 load, 4 store, 5 branch. A stall is raised exactly when a valid stage-1 instruction hits a stage-2 writer it cannot bypass from: a branch reading a non-compare destination, or a load/store base reading a non-immediate destination. A stall lasts one cycle, and stage 2 is empty in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s1_valid | input | 1 | Stage-1 instruction present |
| s1_cls | input | 3 | Stage-1 instruction class code |
| s1_rs_a | input | log2(NREG) | First source index (also address base) |
| s1_rs_b | input | log2(NREG) | Second source index |
| s1_rd | input | log2(NREG) | Destination index |
| s1_wen | input | 1 | Stage-1 instruction writes its destination |
| s2_alu_result | input | XLEN | ALU output of the stage-2 instruction |
| s2_load_data | input | XLEN | Cache read data of the stage-2 instruction |
| stall | output | 1 | Hold stage 1 this cycle |
| s2_live | output | 1 | Stage 2 holds a real instruction |
| s2_sel_a | output | 2 | Registered select for first stage-2 operand |
| s2_sel_b | output | 2 | Registered select for second stage-2 operand |
| s2_opnd_a | output | XLEN | First stage-2 operand after bypass |
| s2_opnd_b | output | XLEN | Second stage-2 operand after bypass |
| s1_cmp_sel_a | output | 2 | Early select, comparator first input |
| s1_cmp_sel_b | output | 2 | Early select, comparator second input |
| s1_addr_sel | output | 2 | Early select, address adder base |
| s1_cmp_a | output | XLEN | Comparator first input value |
| s1_cmp_b | output | XLEN | Comparator second input value |
| s1_addr_base | output | XLEN | Address adder base value |

## Verification
In a single cycle, the stage-1 early path can forward the live ALU output to a branch while the stage-2 mux reads the held writeback value for an older instruction. This happens when a writer, a compare and a branch follow one another on a handful of registers. A long deterministic pseudo-random stream uses only four registers and all six classes, so this overlap occurs often, as do double matches and register 0. Each operand and select is judged against an architectural register model and the select rules of the requirements.

// File: rtl/bhc_pkg.sv
`timescale 1ns/1ps
package bhc_pkg;
   typedef enum logic [2:0] {
      CLS_ALU    = 3'd0,
      CLS_IMM    = 3'd1,
      CLS_SLT    = 3'd2,
      CLS_LOAD   = 3'd3,
      CLS_STORE  = 3'd4,
      CLS_BRANCH = 3'd5
   } iclass_t;

   typedef enum logic [1:0] {
      SEL_RF  = 2'd0,
      SEL_ALU = 2'd1,
      SEL_LD  = 2'd2,
      SEL_WB  = 2'd3
   } osel_t;
endpackage

// File: rtl/bhc_regfile.sv
`timescale 1ns/1ps
module bhc_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int RW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [RW-1:0]   wa,
   input  logic [XLEN-1:0] wd,
   input  logic [RW-1:0]   ra_a,
   input  logic [RW-1:0]   ra_b,
   output logic [XLEN-1:0] rd_a,
   output logic [XLEN-1:0] rd_b
);
   logic [XLEN-1:0] cells [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_cell
      if (g == 0) begin : g_zero
         assign cells[g] = '0;
      end else begin : g_store
         logic [XLEN-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)                       q <= '0;
            else if (we && (wa == RW'(g)))    q <= wd;
         end
         assign cells[g] = q;
      end
   end

   assign rd_a = cells[ra_a];
   assign rd_b = cells[ra_b];
endmodule

// File: rtl/bhc_src_match.sv
`timescale 1ns/1ps
module bhc_src_match
   import bhc_pkg::*;
#(
   parameter int RW = 5
) (
   input  logic          [RW-1:0] rs,
   input  logic                   s2_live,
   input  logic                   s2_wen,
   input  logic          [RW-1:0] s2_rd,
   input  logic          [2:0]    s2_cls,
   input  logic                   s3_live,
   input  logic                   s3_wen,
   input  logic          [RW-1:0] s3_rd,
   output logic                   hit2,
   output logic          [1:0]    early_sel,
   output logic          [1:0]    next_sel
);
   logic nz, hit3;

   assign nz   = (rs != '0);
   assign hit2 = nz && s2_live && s2_wen && (s2_rd == rs);
   assign hit3 = nz && s3_live && s3_wen && (s3_rd == rs);

   always_comb begin
      if (hit2) begin
         early_sel = SEL_ALU;
         next_sel  = (s2_cls == CLS_LOAD) ? SEL_LD : SEL_ALU;
      end else if (hit3) begin
         early_sel = SEL_WB;
         next_sel  = SEL_WB;
      end else begin
         early_sel = SEL_RF;
         next_sel  = SEL_RF;
      end
   end
endmodule

// File: rtl/bhc_mux4.sv
`timescale 1ns/1ps
module bhc_mux4 #(
   parameter int W = 32
) (
   input  logic [1:0]   sel,
   input  logic [W-1:0] d0,
   input  logic [W-1:0] d1,
   input  logic [W-1:0] d2,
   input  logic [W-1:0] d3,
   output logic [W-1:0] y
);
   always_comb begin
      case (sel)
         2'd0:    y = d0;
         2'd1:    y = d1;
         2'd2:    y = d2;
         default: y = d3;
      endcase
   end
endmodule

// File: rtl/bypass_hazard_ctrl.sv
`timescale 1ns/1ps
module bypass_hazard_ctrl
   import bhc_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int RW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            s1_valid,
   input  logic [2:0]      s1_cls,
   input  logic [RW-1:0]   s1_rs_a,
   input  logic [RW-1:0]   s1_rs_b,
   input  logic [RW-1:0]   s1_rd,
   input  logic            s1_wen,
   input  logic [XLEN-1:0] s2_alu_result,
   input  logic [XLEN-1:0] s2_load_data,
   output logic            stall,
   output logic            s2_live,
   output logic [1:0]      s2_sel_a,
   output logic [1:0]      s2_sel_b,
   output logic [XLEN-1:0] s2_opnd_a,
   output logic [XLEN-1:0] s2_opnd_b,
   output logic [1:0]      s1_cmp_sel_a,
   output logic [1:0]      s1_cmp_sel_b,
   output logic [1:0]      s1_addr_sel,
   output logic [XLEN-1:0] s1_cmp_a,
   output logic [XLEN-1:0] s1_cmp_b,
   output logic [XLEN-1:0] s1_addr_base
);
   localparam int NSRC = 2;

   if (XLEN < 2) begin : g_bad_xlen
      $error("bypass_hazard_ctrl: XLEN must be at least 2");
   end
   if ((NREG < 2) || ((NREG & (NREG - 1)) != 0)) begin : g_bad_nreg
      $error("bypass_hazard_ctrl: NREG must be a power of two, at least 2");
   end

   // Stage-2 state
   logic            s2_live_q, s2_wen_q;
   logic [RW-1:0]   s2_rd_q;
   logic [2:0]      s2_cls_q;
   logic [RW-1:0]   s2_rs_q  [NSRC];
   logic [1:0]      s2_sel_q [NSRC];
   logic [XLEN-1:0] s2_op_q  [NSRC];
   // Stage-3 state
   logic            s3_live_q, s3_wen_q;
   logic [RW-1:0]   s3_rd_q;
   logic [2:0]      s3_cls_q;
   logic [XLEN-1:0] s3_alu_q, s3_ld_q, wb_hold_q;

   logic [RW-1:0]   src_idx [NSRC];
   logic [XLEN-1:0] rf_val  [NSRC];
   logic            hit2    [NSRC];
   logic [1:0]      esel    [NSRC];
   logic [1:0]      nsel    [NSRC];
   logic [XLEN-1:0] s1_fwd  [NSRC];
   logic [XLEN-1:0] s2_fwd  [NSRC];
   logic [XLEN-1:0] s3_val;
   logic            wb_en, is_br, is_mem, br_hz, ag_hz, issue;

   assign src_idx[0] = s1_rs_a;
   assign src_idx[1] = s1_rs_b;

   assign s3_val = (s3_cls_q == CLS_LOAD) ? s3_ld_q : s3_alu_q;
   assign wb_en  = s3_live_q && s3_wen_q && (s3_rd_q != '0);

   bhc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(wb_en), .wa(s3_rd_q), .wd(s3_val),
      .ra_a(s1_rs_a), .ra_b(s1_rs_b), .rd_a(rf_val[0]), .rd_b(rf_val[1])
   );

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      bhc_src_match #(.RW(RW)) u_match (
         .rs(src_idx[i]),
         .s2_live(s2_live_q), .s2_wen(s2_wen_q), .s2_rd(s2_rd_q), .s2_cls(s2_cls_q),
         .s3_live(s3_live_q), .s3_wen(s3_wen_q), .s3_rd(s3_rd_q),
         .hit2(hit2[i]), .early_sel(esel[i]), .next_sel(nsel[i])
      );
      bhc_mux4 #(.W(XLEN)) u_s1_mux (
         .sel(esel[i]), .d0(rf_val[i]), .d1(s2_alu_result),
         .d2(s2_load_data), .d3(s3_val), .y(s1_fwd[i])
      );
      bhc_mux4 #(.W(XLEN)) u_s2_mux (
         .sel(s2_sel_q[i]), .d0(s2_op_q[i]), .d1(s3_alu_q),
         .d2(s3_ld_q), .d3(wb_hold_q), .y(s2_fwd[i])
      );
   end

   // Hazards that no bypass path covers
   assign is_br  = (s1_cls == CLS_BRANCH);
   assign is_mem = (s1_cls == CLS_LOAD) || (s1_cls == CLS_STORE);
   assign br_hz  = is_br  && (hit2[0] || hit2[1]) && (s2_cls_q != CLS_SLT);
   assign ag_hz  = is_mem && hit2[0] && (s2_cls_q != CLS_IMM);
   assign stall  = s1_valid && (br_hz || ag_hz);
   assign issue  = s1_valid && !stall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_live_q <= 1'b0;
         s2_wen_q  <= 1'b0;
         s2_rd_q   <= '0;
         s2_cls_q  <= CLS_ALU;
         s3_live_q <= 1'b0;
         s3_wen_q  <= 1'b0;
         s3_rd_q   <= '0;
         s3_cls_q  <= CLS_ALU;
         s3_alu_q  <= '0;
         s3_ld_q   <= '0;
         wb_hold_q <= '0;
         for (int i = 0; i < NSRC; i++) begin
            s2_rs_q[i]  <= '0;
            s2_sel_q[i] <= SEL_RF;
            s2_op_q[i]  <= '0;
         end
      end else begin
         s3_live_q <= s2_live_q;
         s3_wen_q  <= s2_wen_q;
         s3_rd_q   <= s2_rd_q;
         s3_cls_q  <= s2_cls_q;
         s3_alu_q  <= s2_alu_result;
         s3_ld_q   <= s2_load_data;
         if (wb_en) wb_hold_q <= s3_val;
         s2_live_q <= issue;
         if (issue) begin
            s2_wen_q <= s1_wen;
            s2_rd_q  <= s1_rd;
            s2_cls_q <= s1_cls;
         end
         for (int i = 0; i < NSRC; i++) begin
            if (issue) begin
               s2_rs_q[i]  <= src_idx[i];
               s2_sel_q[i] <= nsel[i];
               s2_op_q[i]  <= rf_val[i];
            end else begin
               s2_rs_q[i]  <= '0;
               s2_sel_q[i] <= SEL_RF;
            end
         end
      end
   end

   assign s2_live      = s2_live_q;
   assign s2_sel_a     = s2_sel_q[0];
   assign s2_sel_b     = s2_sel_q[1];
   assign s2_opnd_a    = s2_fwd[0];
   assign s2_opnd_b    = s2_fwd[1];
   assign s1_cmp_sel_a = esel[0];
   assign s1_cmp_sel_b = esel[1];
   assign s1_addr_sel  = esel[0];
   assign s1_cmp_a     = s1_fwd[0];
   assign s1_cmp_b     = s1_fwd[1];
   assign s1_addr_base = s1_fwd[0];

   AST_STALL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall); // R10
   AST_STALL_LEAVES_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !s2_live_q); // R10
   AST_ZERO_REG_UNBYPASSED: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_live_q && (s2_sel_q[0] != SEL_RF)) |-> (s2_rs_q[0] != '0)); // R5
   AST_LOAD_CODE_HAS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_live_q && (s2_sel_q[1] == SEL_LD)) |-> (s3_live_q && (s3_cls_q == CLS_LOAD))); // R2
   AST_COMPARE_BRANCH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && is_br && s2_live_q && (s2_cls_q == CLS_SLT)) |-> !stall); // R7
   AST_IMM_ADDRESS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && is_mem && s2_live_q && (s2_cls_q == CLS_IMM)) |-> !stall); // R8
   AST_EXEC_CLASS_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && (s1_cls <= CLS_SLT)) |-> !stall); // R6
endmodule

// File: tb/bypass_hazard_ctrl_bench.sv
`timescale 1ns/1ps
module bypass_hazard_ctrl_bench;
   localparam int XW   = 16;
   localparam int NR   = 4;
   localparam int RW   = 2;
   localparam int MAXI = 4096;
   localparam int NCYC = 4000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          s1_valid, s1_wen;
   logic [2:0]    s1_cls;
   logic [RW-1:0] s1_rs_a, s1_rs_b, s1_rd;
   logic [XW-1:0] s2_alu_result, s2_load_data;
   logic          stall, s2_live;
   logic [1:0]    s2_sel_a, s2_sel_b, s1_cmp_sel_a, s1_cmp_sel_b, s1_addr_sel;
   logic [XW-1:0] s2_opnd_a, s2_opnd_b, s1_cmp_a, s1_cmp_b, s1_addr_base;

   always #5 clk = ~clk;

   bypass_hazard_ctrl #(.XLEN(XW), .NREG(NR)) u_bypass_hazard_ctrl (
      .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_cls(s1_cls),
      .s1_rs_a(s1_rs_a), .s1_rs_b(s1_rs_b), .s1_rd(s1_rd), .s1_wen(s1_wen),
      .s2_alu_result(s2_alu_result), .s2_load_data(s2_load_data),
      .stall(stall), .s2_live(s2_live), .s2_sel_a(s2_sel_a), .s2_sel_b(s2_sel_b),
      .s2_opnd_a(s2_opnd_a), .s2_opnd_b(s2_opnd_b),
      .s1_cmp_sel_a(s1_cmp_sel_a), .s1_cmp_sel_b(s1_cmp_sel_b), .s1_addr_sel(s1_addr_sel),
      .s1_cmp_a(s1_cmp_a), .s1_cmp_b(s1_cmp_b), .s1_addr_base(s1_addr_base)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   int            i_cls [MAXI];
   int            i_rsa [MAXI], i_rsb [MAXI], i_rd [MAXI];
   bit            i_wen [MAXI];
   logic [XW-1:0] e_opa [MAXI], e_opb [MAXI];
   int            e_sla [MAXI], e_slb [MAXI];
   string         t_a [MAXI], t_b [MAXI];
   logic [XW-1:0] arch [NR];
   int unsigned   seed = 32'h1234_5678;
   int            nid = 0, cur = 0, p2 = -1, p3 = -1;
   bit            cur_valid = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [XW-1:0] valof(input int id);
      return XW'(id * 40503 + 7);
   endfunction

   function automatic int rnd(input int m);
      seed = seed * 1103515245 + 12345;
      return int'((seed >> 16) & 32'h7fff) % m;
   endfunction

   task automatic next_instr();
      cur_valid = (rnd(8) != 0);
      if (cur_valid) begin
         cur = nid;
         nid++;
         i_cls[cur] = rnd(6);
         i_rsa[cur] = rnd(NR);
         i_rsb[cur] = rnd(NR);
         i_rd[cur]  = rnd(NR);
         i_wen[cur] = (i_cls[cur] <= 3) && (rnd(8) != 0);
      end
   endtask

   function automatic bit writes(input int id, input int r);
      return (id >= 0) && i_wen[id] && (i_rd[id] == r) && (r != 0);
   endfunction

   task automatic reset_checks(input string when);
      chk({"R1 stall ", when}, int'(stall), 0);
      chk({"R1 s2_live ", when}, int'(s2_live), 0);
      chk({"R1 s2_sel_a ", when}, int'(s2_sel_a), 0);
      chk({"R1 s2_sel_b ", when}, int'(s2_sel_b), 0);
      chk({"R1 s2_opnd_a ", when}, int'(s2_opnd_a), 0);
      chk({"R1 s2_opnd_b ", when}, int'(s2_opnd_b), 0);
   endtask

   initial begin
      rst_n = 1'b0;
      s1_valid = 1'b0; s1_cls = '0; s1_rs_a = '0; s1_rs_b = '0; s1_rd = '0; s1_wen = 1'b0;
      s2_alu_result = '0; s2_load_data = '0;
      for (int r = 0; r < NR; r++) arch[r] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      reset_checks("in reset");
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      reset_checks("after release");
      next_instr();
      for (int cyc = 0; cyc < NCYC && nid < MAXI - 2; cyc++) begin
         bit    h2a, h2b, h3a, h3b, exp_stall, br, mem;
         int    pc;
         string st;
         pc = (p2 >= 0) ? i_cls[p2] : -1;
         s2_alu_result = (p2 < 0) ? XW'(16'hDEAD) : (pc == 3) ? ~valof(p2) : valof(p2);
         s2_load_data  = (pc == 3) ? valof(p2) : XW'(16'hBEEF);
         s1_valid = cur_valid;
         s1_cls   = cur_valid ? 3'(i_cls[cur]) : 3'd0;
         s1_rs_a  = cur_valid ? RW'(i_rsa[cur]) : '0;
         s1_rs_b  = cur_valid ? RW'(i_rsb[cur]) : '0;
         s1_rd    = cur_valid ? RW'(i_rd[cur]) : '0;
         s1_wen   = cur_valid && i_wen[cur];
         #1;
         h2a = cur_valid && writes(p2, i_rsa[cur]);
         h2b = cur_valid && writes(p2, i_rsb[cur]);
         h3a = cur_valid && writes(p3, i_rsa[cur]);
         h3b = cur_valid && writes(p3, i_rsb[cur]);
         br  = cur_valid && (i_cls[cur] == 5);
         mem = cur_valid && ((i_cls[cur] == 3) || (i_cls[cur] == 4));
         exp_stall = (br && (h2a || h2b) && (pc != 2)) || (mem && h2a && (pc != 1));

         if (exp_stall)                        st = "R10 stall raised";
         else if (br && (h2a || h2b))          st = "R7 compare-branch no stall";
         else if (mem && h2a)                  st = "R8 imm-address no stall";
         else if (pc == 3 && (h2a || h2b))     st = "R6 load-use no stall";
         else                                  st = "R10 no hazard";
         chk(st, int'(stall), int'(exp_stall));
         chk("R10 stage-2 occupancy", int'(s2_live), int'(p2 >= 0));

         if (p2 >= 0) begin
            chk({t_a[p2], " stage-2 select a"}, int'(s2_sel_a), e_sla[p2]);
            chk({t_b[p2], " stage-2 select b"}, int'(s2_sel_b), e_slb[p2]);
            chk({t_a[p2], " stage-2 operand a"}, int'(s2_opnd_a), int'(e_opa[p2]));
            chk({t_b[p2], " stage-2 operand b"}, int'(s2_opnd_b), int'(e_opb[p2]));
         end

         if (cur_valid && !exp_stall) begin
            int ea, eb;
            ea = h2a ? 1 : h3a ? 3 : 0;
            eb = h2b ? 1 : h3b ? 3 : 0;
            if (br) begin
               chk(h2a ? "R7 comparator select a" : "R9 comparator select a", int'(s1_cmp_sel_a), ea);
               chk(h2b ? "R7 comparator select b" : "R9 comparator select b", int'(s1_cmp_sel_b), eb);
               chk(h2a ? "R7 comparator value a" : "R9 comparator value a", int'(s1_cmp_a), int'(arch[i_rsa[cur]]));
               chk(h2b ? "R7 comparator value b" : "R9 comparator value b", int'(s1_cmp_b), int'(arch[i_rsb[cur]]));
            end
            if (mem) begin
               chk(h2a ? "R8 address select" : "R9 address select", int'(s1_addr_sel), ea);
               chk(h2a ? "R8 address base" : "R9 address base", int'(s1_addr_base), int'(arch[i_rsa[cur]]));
            end
            // expected stage-2 view of this instruction, per R2/R3/R4/R5
            e_sla[cur] = h2a ? ((pc == 3) ? 2 : 1) : h3a ? 3 : 0;
            e_slb[cur] = h2b ? ((pc == 3) ? 2 : 1) : h3b ? 3 : 0;
            e_opa[cur] = arch[i_rsa[cur]];
            e_opb[cur] = arch[i_rsb[cur]];
            t_a[cur] = (h2a && h3a) ? "R4" : (i_rsa[cur] == 0) ? "R5" : (pc == 3 && h2a) ? "R6" : "R3";
            t_b[cur] = (h2b && h3b) ? "R4" : (i_rsb[cur] == 0) ? "R5" : (pc == 3 && h2b) ? "R6" : "R3";
            if (i_wen[cur] && i_rd[cur] != 0) arch[i_rd[cur]] = valof(cur);
            p3 = p2;
            p2 = cur;
            next_instr();
         end else if (!cur_valid) begin
            p3 = p2;
            p2 = -1;
            next_instr();
         end else begin
            p3 = p2;
            p2 = -1;
         end
         @(posedge clk);
         @(negedge clk);
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #((NCYC + 100) * 10 * 2);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R10 actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule